// File: doc/BRIEF.md
# Ladder Key-Bit Conditional Swap Unit

This block sequences the secret-dependent part of a Montgomery-ladder scalar multiplication. A start pulse captures an m-bit scalar. The unit loads its first operand register with a fixed constant and its second with a base point, which is streamed in as words. It then walks the scalar from the top bit down to bit 0. For every bit it exchanges the two operands under control of that bit, ships both operands word by word to an external double-and-add engine, and waits for that engine's acknowledge. It then takes the two results back word by word and applies the same exchange again.

The exchange is a masked XOR select and not a branch. It runs for a fixed number of cycles and writes both registers on every one of those cycles, whatever the bit value. Each element is s words of w bits, and every transfer moves the least significant word first. After the last bit the two registers hold the ladder outputs [k]P and [k+1]P. A one-cycle done pulse marks the end of the run, and the stored scalar is wiped at the same moment.

Top module: `ladder_swap_unit`

## Requirements
- R1: In the cycle start is sampled high while idle, the unit captures scalarIn and loads the first register with START_CONST. loadReq is then high for exactly WORD_CNT cycles. The unit takes baseWord in each of these cycles, least significant word first, into the second register.
- R2: Scalar bits are processed from SCALAR_BITS-1 down to 0. Take a double-and-add engine that returns (2X, X+Y) modulo 2^(WORD_W·WORD_CNT), with START_CONST zero. Then resK ends as k·base and resK1 as (k+1)·base, both modulo that power.
- R3: Before each send, a key bit of 0 leaves the operand order unchanged and a key bit of 1 exchanges the two registers. The same exchange is applied again after the results return.
- R4: After each pre-send exchange, opValid is high for exactly 2·WORD_CNT cycles. opWord carries the first register's words low first, then the second register's words. dblReq rises in the cycle after the last word.
- R5: dblReq stays high until dblAck is sampled high while dblReq is high. dblAck in any other cycle, including while opValid is high, has no effect.
- R6: In the cycle after dblAck is accepted, resTake goes high for exactly 2·WORD_CNT cycles. The unit takes resWord in each of these cycles, low word first: the first WORD_CNT words go to the first register and the rest go to the second.
- R7: From the cycle after start is accepted to the done cycle, the run takes WORD_CNT + SCALAR_BITS·(6·WORD_CNT + A) cycles, where A is the number of cycles dblReq is high in each iteration. The count does not depend on the scalar value.
- R8: done is high for one cycle, right after the post-return exchange of bit 0. resK and resK1 hold the results in that cycle, and the stored scalar is zero.
- R9: start is ignored while a run is in progress, including the done cycle itself.
- R10: After reset, loadReq, opValid, dblReq, resTake and done are low, and at most one of them is ever high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run |
| scalarIn | input | SCALAR_BITS | Secret scalar, captured on start |
| baseWord | input | WORD_W | Base point word during loading |
| loadReq | output | 1 | Base word taken this cycle |
| opValid | output | 1 | opWord carries an operand word |
| opWord | output | WORD_W | Operand word to the double-and-add engine |
| dblReq | output | 1 | Request to the double-and-add engine |
| dblAck | input | 1 | Engine has finished |
| resTake | output | 1 | resWord taken this cycle |
| resWord | input | WORD_W | Result word from the engine |
| done | output | 1 | Run complete, one cycle |
| resK | output | WORD_W·WORD_CNT | First register, [k]P |
| resK1 | output | WORD_W·WORD_CNT | Second register, [k+1]P |

## Verification
A new start can collide with the end of a run, and a stray acknowledge can arrive while operands are still being sent. The bench provokes the first collision in two ways: it holds start high in the done cycle, and it pulses start partway through a run. It then requires that loadReq stays low afterwards and that the finished results are the ones the original scalar predicts. The second collision is provoked by a stub engine that raises dblAck during every opValid cycle of one run. That run is judged by unchanged results and by a cycle count that still matches R7 for the programmed wait.

// File: rtl/ladder_swap_pkg.sv
package ladder_swap_pkg;
  typedef struct packed {
    logic loadConst;
    logic loadBase;
    logic swapStep;
    logic sendStep;
    logic recvStep;
    logic selV2;
  } ladderStrobe_t;
endpackage

// File: rtl/ladder_regs.sv
module ladder_regs
  import ladder_swap_pkg::*;
#(
  parameter int WORD_W = 34,
  parameter int WORD_CNT = 4,
  parameter logic [WORD_W*WORD_CNT-1:0] START_CONST = '0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ladderStrobe_t                strobe,
  input  logic                         keyBit,
  input  logic [WORD_W-1:0]            baseWord,
  input  logic [WORD_W-1:0]            resWord,
  output logic [WORD_W-1:0]            opWord,
  output logic [WORD_W*WORD_CNT-1:0]   regA,
  output logic [WORD_W*WORD_CNT-1:0]   regB
);
  localparam int ELEM_W = WORD_W * WORD_CNT;

  logic [WORD_W-1:0] loA, loB, inA, inB, mask, diff;
  logic [ELEM_W-1:0] shA, shB;
  logic enA, enB;

  assign loA  = regA[WORD_W-1:0];
  assign loB  = regB[WORD_W-1:0];
  assign mask = {WORD_W{keyBit}};
  assign diff = (loA ^ loB) & mask;
  assign opWord = strobe.selV2 ? loB : loA;

  always_comb begin
    inA = loA;
    inB = loB;
    enA = 1'b0;
    enB = 1'b0;
    if (strobe.swapStep) begin
      inA = loA ^ diff;
      inB = loB ^ diff;
      enA = 1'b1;
      enB = 1'b1;
    end
    if (strobe.loadBase) begin
      inB = baseWord;
      enB = 1'b1;
    end
    if (strobe.sendStep) begin
      if (strobe.selV2) enB = 1'b1;
      else              enA = 1'b1;
    end
    if (strobe.recvStep) begin
      if (strobe.selV2) begin
        inB = resWord;
        enB = 1'b1;
      end else begin
        inA = resWord;
        enA = 1'b1;
      end
    end
  end

  generate
    if (WORD_CNT > 1) begin : gMulti
      assign shA = {inA, regA[ELEM_W-1:WORD_W]};
      assign shB = {inB, regB[ELEM_W-1:WORD_W]};
    end else begin : gSingle
      assign shA = inA;
      assign shB = inB;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else begin
      if (strobe.loadConst) regA <= START_CONST;
      else if (enA)         regA <= shA;
      if (enB)              regB <= shB;
    end
  end
endmodule

// File: rtl/ladder_seq.sv
module ladder_seq
  import ladder_swap_pkg::*;
#(
  parameter int SCALAR_BITS = 16,
  parameter int WORD_CNT = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [SCALAR_BITS-1:0] scalarIn,
  input  logic                   dblAck,
  output ladderStrobe_t          strobe,
  output logic                   keyBit,
  output logic [SCALAR_BITS-1:0] keyState,
  output logic                   loadReq,
  output logic                   opValid,
  output logic                   dblReq,
  output logic                   resTake,
  output logic                   done
);
  localparam int BIT_W = $clog2(SCALAR_BITS);
  localparam int CNT_W = $clog2(2 * WORD_CNT) + 1;
  localparam logic [CNT_W-1:0] LAST_ONE = CNT_W'(WORD_CNT - 1);
  localparam logic [CNT_W-1:0] LAST_TWO = CNT_W'(2 * WORD_CNT - 1);
  localparam logic [CNT_W-1:0] HALF     = CNT_W'(WORD_CNT);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SWAP_PRE, ST_SEND, ST_WAIT, ST_RECV, ST_SWAP_POST, ST_DONE
  } seqState_t;

  seqState_t state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitIdx;
  logic [SCALAR_BITS-1:0] keyReg;

  assign keyBit   = keyReg[bitIdx];
  assign keyState = keyReg;
  assign loadReq  = (state == ST_LOAD);
  assign opValid  = (state == ST_SEND);
  assign dblReq   = (state == ST_WAIT);
  assign resTake  = (state == ST_RECV);
  assign done     = (state == ST_DONE);

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE:      strobe.loadConst = start;
      ST_LOAD:      strobe.loadBase = 1'b1;
      ST_SWAP_PRE,
      ST_SWAP_POST: strobe.swapStep = 1'b1;
      ST_SEND: begin
        strobe.sendStep = 1'b1;
        strobe.selV2 = (cnt >= HALF);
      end
      ST_RECV: begin
        strobe.recvStep = 1'b1;
        strobe.selV2 = (cnt >= HALF);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      keyReg <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          keyReg <= scalarIn;
          bitIdx <= BIT_W'(SCALAR_BITS - 1);
          cnt    <= '0;
          state  <= ST_LOAD;
        end
        ST_LOAD, ST_SWAP_PRE: if (cnt == LAST_ONE) begin
          cnt   <= '0;
          state <= (state == ST_LOAD) ? ST_SWAP_PRE : ST_SEND;
        end else cnt <= cnt + CNT_W'(1);
        ST_SEND: if (cnt == LAST_TWO) begin
          cnt   <= '0;
          state <= ST_WAIT;
        end else cnt <= cnt + CNT_W'(1);
        ST_WAIT: if (dblAck) state <= ST_RECV;
        ST_RECV: if (cnt == LAST_TWO) begin
          cnt   <= '0;
          state <= ST_SWAP_POST;
        end else cnt <= cnt + CNT_W'(1);
        ST_SWAP_POST: if (cnt == LAST_ONE) begin
          cnt <= '0;
          if (bitIdx == '0) begin
            keyReg <= '0;
            state  <= ST_DONE;
          end else begin
            bitIdx <= bitIdx - BIT_W'(1);
            state  <= ST_SWAP_PRE;
          end
        end else cnt <= cnt + CNT_W'(1);
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ladder_swap_unit.sv
module ladder_swap_unit
  import ladder_swap_pkg::*;
#(
  parameter int SCALAR_BITS = 16,
  parameter int WORD_W = 34,
  parameter int WORD_CNT = 4,
  parameter logic [WORD_W*WORD_CNT-1:0] START_CONST = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [SCALAR_BITS-1:0]     scalarIn,
  input  logic [WORD_W-1:0]          baseWord,
  output logic                       loadReq,
  output logic                       opValid,
  output logic [WORD_W-1:0]          opWord,
  output logic                       dblReq,
  input  logic                       dblAck,
  output logic                       resTake,
  input  logic [WORD_W-1:0]          resWord,
  output logic                       done,
  output logic [WORD_W*WORD_CNT-1:0] resK,
  output logic [WORD_W*WORD_CNT-1:0] resK1
);
  ladderStrobe_t strobe;
  logic keyBit;
  logic [SCALAR_BITS-1:0] keyState;

  ladder_seq #(.SCALAR_BITS(SCALAR_BITS), .WORD_CNT(WORD_CNT)) uSeq (
    .clk(clk), .rstN(rstN), .start(start), .scalarIn(scalarIn), .dblAck(dblAck),
    .strobe(strobe), .keyBit(keyBit), .keyState(keyState),
    .loadReq(loadReq), .opValid(opValid), .dblReq(dblReq),
    .resTake(resTake), .done(done)
  );

  ladder_regs #(.WORD_W(WORD_W), .WORD_CNT(WORD_CNT), .START_CONST(START_CONST)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .keyBit(keyBit),
    .baseWord(baseWord), .resWord(resWord), .opWord(opWord),
    .regA(resK), .regB(resK1)
  );
endmodule

// File: rtl/ladder_swap_chk.sv
module ladder_swap_chk #(
  parameter int KEY_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             loadReq,
  input logic             opValid,
  input logic             dblReq,
  input logic             dblAck,
  input logic             resTake,
  input logic             done,
  input logic [KEY_W-1:0] keyState
);
  assert_one_phase_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadReq, opValid, dblReq, resTake, done}));

  assert_req_after_send_R4: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> (opValid || dblReq));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dblReq && !dblAck) |=> dblReq);

  assert_ack_to_take_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dblReq && dblAck) |=> resTake);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_key_wiped_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (keyState == '0));

  assert_done_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !loadReq);
endmodule

bind ladder_swap_unit ladder_swap_chk #(.KEY_W(SCALAR_BITS)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .loadReq(loadReq), .opValid(opValid),
  .dblReq(dblReq), .dblAck(dblAck), .resTake(resTake), .done(done),
  .keyState(keyState)
);

// File: tb/tb_ladder_swap_unit.sv
module tb_ladder_swap_unit;
  localparam int M = 4;
  localparam int W = 8;
  localparam int S = 2;
  localparam int E = W * S;
  localparam int EMASK = (1 << E) - 1;
  localparam int WMASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [M-1:0] scalarIn = '0;
  logic [W-1:0] baseWord = '0;
  logic [W-1:0] resWord = '0;
  logic dblAck = 1'b0;
  logic loadReq, opValid, dblReq, resTake, done;
  logic [W-1:0] opWord;
  logic [E-1:0] resK, resK1;

  always #4 clk = ~clk;

  ladder_swap_unit #(.SCALAR_BITS(M), .WORD_W(W), .WORD_CNT(S), .START_CONST('0)) dut (
    .clk(clk), .rstN(rstN), .start(start), .scalarIn(scalarIn), .baseWord(baseWord),
    .loadReq(loadReq), .opValid(opValid), .opWord(opWord), .dblReq(dblReq),
    .dblAck(dblAck), .resTake(resTake), .resWord(resWord), .done(done),
    .resK(resK), .resK1(resK1)
  );

  int total = 0;
  int bad = 0;
  bit wdFired = 0;

  int baseCfg = 0, dlyCfg = 0;
  bit earlyCfg = 0;
  int loadIdx = 0, sendIdx = 0, recvIdx = 0, waitCnt = 0, iterCnt = 0;
  int opX = 0, opY = 0, outX = 0, outY = 0, firstWord = -1;
  bit ackPending = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stub double-and-add engine: returns (2X, X+Y)
  always @(negedge clk) begin
    if (rstN) begin
      if (ackPending) begin
        check(resTake, "R6", "resTake after ack", int'(resTake), 1);
        ackPending = 0;
      end
      if (loadReq) begin
        baseWord = W'(baseCfg >> (W * loadIdx));
        loadIdx++;
      end
      if (opValid) begin
        if (sendIdx == 0 && iterCnt == 0) firstWord = int'(opWord);
        if (sendIdx < S) opX |= int'(opWord) << (W * sendIdx);
        else             opY |= int'(opWord) << (W * (sendIdx - S));
        sendIdx++;
      end
      dblAck = 1'b0;
      if (dblReq) begin
        waitCnt++;
        if (waitCnt == 1) begin
          check(sendIdx == 2 * S, "R4", "words sent before request", sendIdx, 2 * S);
          outX = (2 * opX) & EMASK;
          outY = (opX + opY) & EMASK;
          recvIdx = 0;
        end
        if (waitCnt == dlyCfg + 1) begin
          dblAck = 1'b1;
          ackPending = 1;
        end
      end else waitCnt = 0;
      if (earlyCfg && opValid) dblAck = 1'b1;
      if (resTake) begin
        resWord = (recvIdx < S) ? W'(outX >> (W * recvIdx)) : W'(outY >> (W * (recvIdx - S)));
        recvIdx++;
        if (recvIdx == 2 * S) begin
          sendIdx = 0; opX = 0; opY = 0; iterCnt++;
        end
      end
    end
  end

  task automatic runLadder(input int k, input int base, input int dly, input bit early,
                           input bit midStart, input bit startAtDone);
    int cnt;
    int expLat;
    int expFirst;
    @(negedge clk);
    baseCfg = base; dlyCfg = dly; earlyCfg = early;
    loadIdx = 0; iterCnt = 0; sendIdx = 0; opX = 0; opY = 0; firstWord = -1;
    scalarIn = M'(k);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && !wdFired) begin
      @(negedge clk);
      cnt++;
      if (midStart && cnt == 5) begin
        start = 1'b1;
        scalarIn = M'(k ^ 5);
      end else if (midStart && cnt == 6) start = 1'b0;
    end
    expLat = S + M * (6 * S + dly + 1);
    check(cnt == expLat, early ? "R5" : "R7", "cycles start to done", cnt, expLat);
    check(done, "R8", "done observed", int'(done), 1);
    check(loadIdx == S, "R1", "base words taken", loadIdx, S);
    check(int'(resK) == ((k * base) & EMASK), "R2", "resK", int'(resK), (k * base) & EMASK);
    check(int'(resK1) == (((k + 1) * base) & EMASK), k == 0 ? "R1" : "R2", "resK1",
          int'(resK1), ((k + 1) * base) & EMASK);
    expFirst = ((k >> (M - 1)) & 1) ? (base & WMASK) : 0;
    check(firstWord == expFirst, "R3", "first word sent", firstWord, expFirst);
    if (startAtDone) start = 1'b1;
    @(negedge clk);
    check(!done, "R8", "done one cycle", int'(done), 0);
    start = 1'b0;
    if (startAtDone || midStart) begin
      for (int i = 0; i < 3; i++) begin
        check(!loadReq, "R9", "no new run", int'(loadReq), 0);
        @(negedge clk);
      end
    end
    earlyCfg = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    wdFired = 1;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!loadReq && !opValid && !dblReq && !resTake && !done, "R10", "idle outputs",
          int'({loadReq, opValid, dblReq, resTake, done}), 0);
    check(resK == '0 && resK1 == '0, "R10", "registers zero", int'(resK), 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      for (int k = 0; k < (1 << M); k++) begin
        if (!wdFired) runLadder(k, (b == 0) ? 16'h1234 : (b == 1) ? 16'hBEEF : 16'h0001,
                                k % 3, 1'b0, 1'b0, 1'b0);
      end
    end
    if (!wdFired) runLadder(11, 16'h5A5A, 2, 1'b1, 1'b0, 1'b0);
    if (!wdFired) runLadder(6, 16'h0F0F, 1, 1'b0, 1'b1, 1'b0);
    if (!wdFired) runLadder(9, 16'h7777, 0, 1'b0, 1'b0, 1'b1);
    if (wdFired) check(1'b0, "R7", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule